// File: doc/BRIEF.md
# IEEE 1284 Mode Negotiation Controller

This block is the host side of the handshake that takes an IEEE 1284 parallel link out of compatibility mode into a mode chosen by an 8-bit request code. It can also bring the link back to compatibility mode. A start command carries the request code. The controller places the code on the data lines, runs the numbered event sequence on the host control lines, and watches the peripheral status lines. It then reports whether the peripheral accepted the mode, rejected it, timed out, or whether the command was not legal in the current link state. A terminate command runs the reverse handshake. Data transfer after negotiation is handled elsewhere.

All delays and response windows are counted in ticks. One tick is `TICK_CYC` clock cycles. Every wait step restarts its own counter. The setup delay is `SETUP_T` ticks, the first response window is `RESP_T` ticks, and the acknowledge window is `ACKW_T` ticks. By default these are 1, 6 and 7 ticks. Request code 0x00 selects nibble mode, which a compliant peripheral cannot refuse. Code 0x30 is the usual request for ECP with run-length encoding.

In the status signals below, "the status flags" means accepted, rejected, timeout and protocol error. "The selection request line" is the host's active-low select-in output.

Top module: `p1284_mode_neg`

## Requirements
- R1: After reset, the selection request line is low, strobe and autofeed are high, init is high, the data lines are 0x00, compatibility is reported as 1, and done and all four status flags are 0.
- R2: A start seen while idle with the selection request line already high is refused. One cycle later, done pulses with protocol error set. The data lines and control lines do not change.
- R3: A start seen while idle with the selection request line low puts the request code on the data lines in the next cycle. The control lines stay unchanged for exactly SETUP_T ticks. Then the selection request line goes high and autofeed goes low, while strobe and init stay high.
- R4: The controller then waits for paper-error, select and fault_n all high and ack_n low. If this has not been seen after RESP_T ticks, done pulses with timeout set.
- R5: Once that reply is seen, strobe goes low one cycle later and stays low for exactly SETUP_T ticks. Then strobe and autofeed both return high.
- R6: The controller then waits up to ACKW_T ticks for ack_n high. If the window expires, done pulses with timeout set.
- R7: On the cycle ack_n is seen high, done pulses. Accepted is set when the request code is 0x00 or when select is high in that same cycle; otherwise rejected is set.
- R8: A terminate seen while idle with the selection request line low is refused. Done pulses with protocol error set, and no line changes.
- R9: A legal terminate drives the selection request line low and sets autofeed and strobe high. It then waits up to ACKW_T ticks for busy and fault_n high with ack_n low. If the window expires, done pulses with protocol error set.
- R10: After that, autofeed goes low and the controller waits up to RESP_T ticks for ack_n high. It then raises autofeed and pulses done with no status flag set. If the wait times out, autofeed is raised and done pulses with protocol error set.
- R11: Compatibility is reported 0 from the cycle the selection request line rises. It is reported 1 again at the end of any termination, whether it succeeded or failed.
- R12: Done is a single-cycle pulse, and at most one status flag is set with it. The status flags hold until the next command.
- R13: Start and terminate are ignored while a sequence is in progress. If both are raised in the same idle cycle, start wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin negotiation |
| req_code_i | input | 8 | Extensibility request code |
| term_i | input | 1 | Begin termination |
| ack_n_i | input | 1 | Peripheral acknowledge, active low |
| busy_i | input | 1 | Peripheral busy |
| paper_err_i | input | 1 | Peripheral paper-error line |
| online_i | input | 1 | Peripheral select line |
| fault_n_i | input | 1 | Peripheral fault, active low |
| data_o | output | 8 | Data lines |
| stb_n_o | output | 1 | Strobe, active low |
| feed_n_o | output | 1 | Autofeed, active low |
| init_n_o | output | 1 | Init, active low |
| sel_req_n_o | output | 1 | Selection request line (active-low select-in) |
| done_o | output | 1 | End-of-command pulse |
| accepted_o | output | 1 | Peripheral accepted the mode |
| rejected_o | output | 1 | Peripheral refused the mode |
| timeout_o | output | 1 | Negotiation response window expired |
| proto_err_o | output | 1 | Illegal command or failed termination |
| compat_o | output | 1 | Link is in compatibility mode, forward direction |

## Verification
The bench builds the block with TICK_CYC=4 and keeps the default tick counts. This gives windows of 4, 24 and 28 cycles. Each peripheral response delay can then be swept cycle by cycle, from zero to two cycles past its window. Both edges of every timeout are checked this way. The acceptance rule is checked for nibble and non-nibble codes with select both high and low. A start is injected during termination to check that commands are ignored while a sequence runs.

// File: rtl/p1284_mode_neg.sv
module p1284_mode_neg #(
  parameter int TICK_CYC = 8,
  parameter int SETUP_T  = 1,
  parameter int RESP_T   = 6,
  parameter int ACKW_T   = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [7:0] req_code_i,
  input  logic       term_i,
  input  logic       ack_n_i,
  input  logic       busy_i,
  input  logic       paper_err_i,
  input  logic       online_i,
  input  logic       fault_n_i,
  output logic [7:0] data_o,
  output logic       stb_n_o,
  output logic       feed_n_o,
  output logic       init_n_o,
  output logic       sel_req_n_o,
  output logic       done_o,
  output logic       accepted_o,
  output logic       rejected_o,
  output logic       timeout_o,
  output logic       proto_err_o,
  output logic       compat_o
);
  localparam int SETUP_CYC = TICK_CYC * SETUP_T;
  localparam int RESP_CYC  = TICK_CYC * RESP_T;
  localparam int ACKW_CYC  = TICK_CYC * ACKW_T;
  localparam int CW = $clog2(SETUP_CYC + RESP_CYC + ACKW_CYC + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_REPLY, ST_LATCH, ST_CONFIRM, ST_TREQ, ST_THS
  } state_t;

  state_t        state;
  logic [CW-1:0] cnt, lim;
  logic [7:0]    data_q;
  logic          sel_q, feed_q, stb_q, done_q, compat_q;
  logic          acc_q, rej_q, to_q, perr_q;
  logic          last, reply_ok, term_ok;

  always_comb begin
    case (state)
      ST_SETUP, ST_LATCH: lim = CW'(SETUP_CYC);
      ST_REPLY, ST_THS:   lim = CW'(RESP_CYC);
      ST_CONFIRM, ST_TREQ: lim = CW'(ACKW_CYC);
      default:            lim = CW'(1);
    endcase
  end

  assign last     = (cnt == lim - CW'(1));
  assign reply_ok = paper_err_i && online_i && fault_n_i && !ack_n_i;
  assign term_ok  = busy_i && fault_n_i && !ack_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt <= '0;
      data_q <= 8'h00;
      sel_q <= 1'b0;
      feed_q <= 1'b1;
      stb_q <= 1'b1;
      done_q <= 1'b0;
      compat_q <= 1'b1;
      {acc_q, rej_q, to_q, perr_q} <= 4'b0;
    end else begin
      done_q <= 1'b0;
      cnt <= cnt + CW'(1);
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (start_i) begin
            {acc_q, rej_q, to_q, perr_q} <= 4'b0;
            if (sel_q) begin
              perr_q <= 1'b1;
              done_q <= 1'b1;
            end else begin
              data_q <= req_code_i;
              state <= ST_SETUP;
            end
          end else if (term_i) begin
            {acc_q, rej_q, to_q, perr_q} <= 4'b0;
            if (!sel_q) begin
              perr_q <= 1'b1;
              done_q <= 1'b1;
            end else begin
              sel_q <= 1'b0;
              feed_q <= 1'b1;
              stb_q <= 1'b1;
              state <= ST_TREQ;
            end
          end
        end
        ST_SETUP: if (last) begin
          sel_q <= 1'b1;
          feed_q <= 1'b0;
          stb_q <= 1'b1;
          compat_q <= 1'b0;
          cnt <= '0;
          state <= ST_REPLY;
        end
        ST_REPLY: begin
          if (reply_ok) begin
            stb_q <= 1'b0;
            cnt <= '0;
            state <= ST_LATCH;
          end else if (last) begin
            to_q <= 1'b1;
            done_q <= 1'b1;
            state <= ST_IDLE;
          end
        end
        ST_LATCH: if (last) begin
          stb_q <= 1'b1;
          feed_q <= 1'b1;
          cnt <= '0;
          state <= ST_CONFIRM;
        end
        ST_CONFIRM: begin
          if (ack_n_i) begin
            done_q <= 1'b1;
            if (data_q == 8'h00 || online_i) acc_q <= 1'b1;
            else rej_q <= 1'b1;
            state <= ST_IDLE;
          end else if (last) begin
            to_q <= 1'b1;
            done_q <= 1'b1;
            state <= ST_IDLE;
          end
        end
        ST_TREQ: begin
          if (term_ok) begin
            feed_q <= 1'b0;
            cnt <= '0;
            state <= ST_THS;
          end else if (last) begin
            perr_q <= 1'b1;
            done_q <= 1'b1;
            compat_q <= 1'b1;
            state <= ST_IDLE;
          end
        end
        ST_THS: begin
          if (ack_n_i || last) begin
            feed_q <= 1'b1;
            done_q <= 1'b1;
            compat_q <= 1'b1;
            perr_q <= !ack_n_i;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign data_o      = data_q;
  assign stb_n_o     = stb_q;
  assign feed_n_o    = feed_q;
  assign init_n_o    = 1'b1;
  assign sel_req_n_o = sel_q;
  assign done_o      = done_q;
  assign accepted_o  = acc_q;
  assign rejected_o  = rej_q;
  assign timeout_o   = to_q;
  assign proto_err_o = perr_q;
  assign compat_o    = compat_q;

  AST_REFUSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && start_i && sel_q) |=> (done_q && perr_q && sel_q && $stable(data_q))); // R2
  AST_EVENT1_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_q) |-> (!feed_q && stb_q)); // R3
  AST_STROBE_CTX: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_q |-> (sel_q && !feed_q)); // R5
  AST_NIBBLE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && rej_q) |-> (data_q != 8'h00)); // R7
  AST_TERM_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_q) |-> (feed_q && stb_q)); // R9
  AST_COMPAT_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    compat_q |-> (!sel_q && feed_q && stb_q)); // R11
  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $onehot0({acc_q, rej_q, to_q, perr_q})); // R12
endmodule

// File: tb/p1284_mode_neg_tb.sv
module p1284_mode_neg_tb;
  localparam int TICK = 4;
  localparam int SC = TICK * 1;
  localparam int RL = TICK * 6;
  localparam int AL = TICK * 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, term = 1'b0;
  logic [7:0] code = 8'h00;
  logic ack_n = 1'b1, busy = 1'b0, perr = 1'b0, onl = 1'b0, flt_n = 1'b1;
  logic [7:0] data;
  logic stb_n, feed_n, init_n, selr_n, done, acc, rej, tmo, perr_o, compat;
  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  p1284_mode_neg #(.TICK_CYC(TICK)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .req_code_i(code), .term_i(term),
    .ack_n_i(ack_n), .busy_i(busy), .paper_err_i(perr), .online_i(onl), .fault_n_i(flt_n),
    .data_o(data), .stb_n_o(stb_n), .feed_n_o(feed_n), .init_n_o(init_n),
    .sel_req_n_o(selr_n), .done_o(done), .accepted_o(acc), .rejected_o(rej),
    .timeout_o(tmo), .proto_err_o(perr_o), .compat_o(compat));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_for_done(output int n);
    n = 0;
    while (!done && n < 1000) begin @(negedge clk); n++; end
  endtask

  task automatic negotiate(input logic [7:0] c, input int d1, input int d2, input logic sv);
    int n;
    code = c; start = 1'b1;
    @(negedge clk); start = 1'b0; n = 1;
    chk("R3 code on data", data, c);
    chk("R3 lines held in setup", {selr_n, feed_n, stb_n, init_n}, 4'b0111);
    while (!selr_n && n < 1000) begin @(negedge clk); n++; end
    chk("R3 setup length", n, 1 + SC);
    chk("R3 event1 lines", {selr_n, feed_n, stb_n, init_n}, 4'b1011);
    chk("R11 compat cleared", compat, 0);
    if (d1 >= RL) begin
      wait_for_done(n);
      chk("R4 reply timeout cycle", n, RL);
      chk("R4 timeout flags", {acc, rej, tmo, perr_o}, 4'b0010);
      @(negedge clk);
      chk("R12 done single cycle", done, 0);
      return;
    end
    repeat (d1) @(negedge clk);
    perr = 1'b1; onl = 1'b1; flt_n = 1'b1; ack_n = 1'b0;
    n = 0;
    while (stb_n && n < 1000) begin @(negedge clk); n++; end
    chk("R5 strobe falls after reply", n, 1);
    onl = sv;
    n = 0;
    while (!stb_n && n < 1000) begin @(negedge clk); n++; end
    chk("R5 strobe width", n, SC);
    chk("R5 autofeed restored", feed_n, 1);
    if (d2 >= AL) begin
      wait_for_done(n);
      chk("R6 ack timeout cycle", n, AL);
      chk("R6 timeout flags", {acc, rej, tmo, perr_o}, 4'b0010);
    end else begin
      repeat (d2) @(negedge clk);
      ack_n = 1'b1;
      @(negedge clk);
      chk("R7 done on ack high", done, 1);
      chk("R7 acceptance", {acc, rej, tmo, perr_o},
          (c == 8'h00 || sv) ? 4'b1000 : 4'b0100);
    end
    @(negedge clk);
    chk("R12 done single cycle", done, 0);
  endtask

  task automatic terminate(input int d3, input int d4, input bit poke);
    int n;
    logic [7:0] held;
    held = data;
    ack_n = 1'b1; busy = 1'b0;
    term = 1'b1;
    @(negedge clk); term = 1'b0;
    chk("R9 termination request lines", {selr_n, feed_n, stb_n, init_n}, 4'b0111);
    if (poke) begin
      code = 8'hA5; start = 1'b1;
      @(negedge clk); start = 1'b0;
      d3 = d3 - 1;
    end
    if (d3 >= AL) begin
      wait_for_done(n);
      chk("R9 termination timeout cycle", n, AL);
      chk("R9 error flag", {acc, rej, tmo, perr_o}, 4'b0001);
      chk("R11 compat after failed termination", compat, 1);
    end else begin
      repeat (d3) @(negedge clk);
      busy = 1'b1; ack_n = 1'b0;
      n = 0;
      while (feed_n && n < 1000) begin @(negedge clk); n++; end
      chk("R10 autofeed lowered", n, 1);
      if (d4 >= RL) begin
        wait_for_done(n);
        chk("R10 handshake timeout cycle", n, RL);
        chk("R10 error flag", {acc, rej, tmo, perr_o}, 4'b0001);
      end else begin
        repeat (d4) @(negedge clk);
        ack_n = 1'b1;
        @(negedge clk);
        chk("R10 done after handshake", done, 1);
        chk("R10 no flags", {acc, rej, tmo, perr_o}, 4'b0000);
      end
      chk("R10 autofeed high at end", feed_n, 1);
      chk("R11 compat after termination", compat, 1);
    end
    if (poke) chk("R13 start ignored while busy", data, held);
    chk("R11 idle lines", {selr_n, feed_n, stb_n}, 3'b011);
    @(negedge clk);
    chk("R12 done single cycle", done, 0);
    busy = 1'b0; perr = 1'b0; onl = 1'b0; ack_n = 1'b1; flt_n = 1'b1;
  endtask

  bit wd_hit = 1'b0;
  initial begin
    #(8 * 150000);
    wd_hit = 1'b1;
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset lines", {selr_n, feed_n, stb_n, init_n}, 4'b0111);
    chk("R1 reset data", data, 8'h00);
    chk("R1 reset status", {done, acc, rej, tmo, perr_o, compat}, 6'b000001);
    rst_n = 1'b1;
    @(negedge clk);

    term = 1'b1;
    @(negedge clk); term = 1'b0;
    chk("R8 refused terminate", {done, perr_o}, 2'b11);
    chk("R8 lines unchanged", {selr_n, feed_n, stb_n, data}, {3'b011, 8'h00});
    @(negedge clk);

    for (int d = 0; d <= RL + 1; d++) begin
      negotiate((d % 2) ? 8'h30 : 8'h00, d, 0, 1'b1);
      terminate(0, 0, 1'b0);
    end
    for (int d = 0; d <= AL + 1; d++) begin
      negotiate(8'h30, 0, d, 1'b1);
      terminate(1, 1, 1'b0);
    end
    for (int i = 0; i < 6; i++) begin
      logic [7:0] c;
      c = (i / 2 == 0) ? 8'h00 : ((i / 2 == 1) ? 8'h30 : 8'h10);
      negotiate(c, 2, 3, i[0]);
      terminate(2, 2, 1'b0);
    end

    negotiate(8'h30, 1, 1, 1'b1);
    code = 8'h10; start = 1'b1; term = 1'b1;
    @(negedge clk); start = 1'b0; term = 1'b0;
    chk("R2 refused start", {done, perr_o}, 2'b11);
    chk("R13 start wins over terminate", selr_n, 1);
    chk("R2 data unchanged", data, 8'h30);
    chk("R2 lines unchanged", {selr_n, feed_n, stb_n}, 3'b111);
    @(negedge clk);
    terminate(5, 2, 1'b1);

    for (int d = 0; d <= AL + 1; d++) begin
      negotiate(8'h00, 0, 0, 1'b0);
      terminate(d, 2, 1'b0);
    end
    for (int d = 0; d <= RL + 1; d++) begin
      negotiate(8'h30, 0, 0, 1'b1);
      terminate(1, d, 1'b0);
    end

    if (!wd_hit) begin
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule